// File: doc/BRIEF.md
# PLL Loop-Bandwidth Mode Register

This block is an 8-bit control and status register for the loop-bandwidth logic of a clock generator's phase-locked loop. Software uses it to choose between automatic and manual bandwidth control. It reads back whether the loop is locked. It also reads or sets whether the loop runs in the wide acquisition mode or the narrow tracking mode. Access is through a simple synchronous register port made of an address, a write strobe, write data and combinational read data.

The lock detector and the bandwidth sequencer sit outside the block and feed it two status lines. In automatic mode the sequencer owns the acquisition/tracking choice, and the register only reports it. In manual mode software owns that choice. A hidden shadow bit keeps the software's choice while automatic mode is active, so the manual setting comes back when software leaves automatic mode. The effective choice goes to the analog loop through a registered output.

Top module: `pll_bw_mode_reg`

## Requirements
- R1: After reset the register reads 0x00, so the block is in manual mode with acquisition selected, and `loop_track` is 0.
- R2: Bits 4 to 0 always read as 0, whatever was written to them.
- R3: Bit 6 (lock) reads the live `hw_lock` input while bit 7 (automatic enable) is 1, and reads 0 while bit 7 is 0.
- R4: A write of 1 to bit 6 changes neither the lock read-back nor any other state.
- R5: While automatic mode is on, bit 5 reads the live `hw_track` input, where 0 means acquisition and 1 means tracking.
- R6: In manual mode, a write with bit 7 = 0 stores bit 5 in the shadow bit. Bit 5 then reads that value, and `loop_track` takes it one clock after the write.
- R7: A write that clears bit 7 while automatic mode is on ignores its own bit 5 and restores the saved shadow value. Both the bit 5 read-back and `loop_track` take the restored value one clock after the write.
- R8: While automatic mode is on, no write changes the shadow bit.
- R9: While automatic mode is on, `loop_track` equals `hw_track` as sampled on the previous clock edge.
- R10: A write with bit 7 = 1 discards its bit 5, even when the block was in manual mode before the write.
- R11: A write strobe on any other address changes nothing, and a read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, 0x00 when the address does not match |
| hw_lock | input | 1 | Lock status from the lock detector |
| hw_track | input | 1 | Status from the bandwidth sequencer, 1 for tracking and 0 for acquisition |
| loop_track | output | 1 | Registered acquisition/tracking control to the loop |

## Verification
The bench sets one value in manual mode, enters automatic mode and writes the opposite value, then leaves automatic mode. A design without a working shadow bit would come back with the wrong manual value. It also enters automatic mode with a mode bit that differs from the saved one and then leaves again. A design that let the entering write through would show the entering write's value in place of the saved one. The bench toggles `hw_lock` in both modes and writes a 1 to the lock bit. A design that gated the lock read-back wrongly, or that stored the written lock bit, would show a 1 in manual mode. Finally it changes `hw_track` while in automatic mode and checks `loop_track` exactly one clock later. This catches an output that is unregistered or that lags by one cycle too many.

// File: rtl/pll_bw_mode_reg.sv
module pll_bw_mode_reg #(
  parameter int          ADDR_W   = 8,
  parameter [ADDR_W-1:0] REG_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              hw_lock,
  input  logic              hw_track,
  output logic              loop_track
);
  localparam int AUTO_BIT  = 7;
  localparam int LOCK_BIT  = 6;
  localparam int TRACK_BIT = 5;

  logic auto_q, shadow_q, auto_d, shadow_d;
  logic sel, wr_hit, mode_wr_ok;

  assign sel        = (bus_addr == REG_ADDR);
  assign wr_hit     = sel && bus_wr;
  assign mode_wr_ok = wr_hit && !bus_wdata[AUTO_BIT] && !auto_q;

  assign auto_d   = wr_hit ? bus_wdata[AUTO_BIT] : auto_q;
  assign shadow_d = mode_wr_ok ? bus_wdata[TRACK_BIT] : shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_q     <= 1'b0;
      shadow_q   <= 1'b0;
      loop_track <= 1'b0;
    end else begin
      auto_q     <= auto_d;
      shadow_q   <= shadow_d;
      loop_track <= auto_d ? hw_track : shadow_d;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (sel) begin
      bus_rdata[AUTO_BIT]  = auto_q;
      bus_rdata[LOCK_BIT]  = auto_q & hw_lock;
      bus_rdata[TRACK_BIT] = auto_q ? hw_track : shadow_q;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[LOCK_BIT], bus_wdata[4:0]};
endmodule

module pll_bw_mode_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_hit,
  input logic       wd_auto,
  input logic       wd_mode,
  input logic       auto_q,
  input logic       shadow_q,
  input logic       hw_track,
  input logic       loop_track,
  input logic       rd_lock,
  input logic [4:0] rd_low
);
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_low == 5'd0);

  p_lock_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_q |-> !rd_lock);

  p_manual_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wd_auto && !auto_q) |=> loop_track == $past(wd_mode));

  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && wr_hit && !wd_auto) |=> loop_track == $past(shadow_q));

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |=> $stable(shadow_q));

  p_auto_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && !(wr_hit && !wd_auto)) |=> loop_track == $past(hw_track));

  p_entry_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wd_auto) |=> $stable(shadow_q));
endmodule

bind pll_bw_mode_reg pll_bw_mode_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_hit     (wr_hit),
  .wd_auto    (bus_wdata[7]),
  .wd_mode    (bus_wdata[5]),
  .auto_q     (auto_q),
  .shadow_q   (shadow_q),
  .hw_track   (hw_track),
  .loop_track (loop_track),
  .rd_lock    (bus_rdata[6]),
  .rd_low     (bus_rdata[4:0])
);

// File: tb/tb_pll_bw_mode_reg.sv
module tb_pll_bw_mode_reg;
  localparam logic [7:0] RA = 8'h1C;
  localparam logic [7:0] OA = 8'h1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = RA;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic hw_lock = 1'b0;
  logic hw_track = 1'b0;
  logic loop_track;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_bw_mode_reg #(.ADDR_W(8), .REG_ADDR(RA)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_lock(hw_lock),
    .hw_track(hw_track), .loop_track(loop_track)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = RA;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    bus_addr = RA;
  endtask

  task automatic t_reset();
    rd_chk("R1", RA, 8'h00);
    check("R1", {7'd0, loop_track}, 8'h01 & 8'h00);
  endtask

  task automatic t_manual();
    wr(RA, 8'h3F);
    rd_chk("R2", RA, 8'h20);
    check("R6", {7'd0, loop_track}, 8'h01);
    wr(RA, 8'h00);
    rd_chk("R6", RA, 8'h00);
    check("R6", {7'd0, loop_track}, 8'h00);
    hw_lock = 1'b1;
    wr(RA, 8'h40);
    rd_chk("R3", RA, 8'h00);
    rd_chk("R4", RA, 8'h00);
    hw_lock = 1'b0;
  endtask

  task automatic t_auto();
    wr(RA, 8'h20);
    hw_lock = 1'b1; hw_track = 1'b0;
    wr(RA, 8'h80);
    rd_chk("R3", RA, 8'hC0);
    rd_chk("R5", RA, 8'hC0);
    check("R9", {7'd0, loop_track}, 8'h00);
    hw_track = 1'b1;
    #1;
    rd_chk("R5", RA, 8'hE0);
    check("R9", {7'd0, loop_track}, 8'h00);
    @(negedge clk);
    check("R9", {7'd0, loop_track}, 8'h01);
    hw_lock = 1'b0;
    rd_chk("R3", RA, 8'hA0);
    hw_track = 1'b0;
    wr(RA, 8'h80);
    check("R9", {7'd0, loop_track}, 8'h00);
    wr(RA, 8'h00);
    rd_chk("R7", RA, 8'h20);
    check("R7", {7'd0, loop_track}, 8'h01);
  endtask

  task automatic t_entry_discard();
    wr(RA, 8'h00);
    hw_track = 1'b0;
    wr(RA, 8'hA0);
    rd_chk("R10", RA, 8'h80);
    wr(RA, 8'h20);
    rd_chk("R10", RA, 8'h00);
    check("R10", {7'd0, loop_track}, 8'h00);
  endtask

  task automatic t_other_addr();
    wr(OA, 8'hA0);
    rd_chk("R11", RA, 8'h00);
    rd_chk("R11", OA, 8'h00);
    wr(RA, 8'h20);
    rd_chk("R11", OA, 8'h00);
    wr(RA, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_manual();
    t_auto();
    t_entry_discard();
    t_other_addr();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule